// File: doc/BRIEF.md
# Register-Pair ALU Execute Stage

This block is the execute stage for the register-to-register arithmetic and logic group of a compact 16-bit instruction encoding that operates on 32-bit data. Each cycle it may accept one instruction word together with the current values of the destination register and the source register, plus the incoming condition flags. It decodes the operation, evaluates it, and presents the registered result, a write strobe for the destination register, the destination index and the new flag set one clock later.

The sixteen operations cover bitwise logic (and, exclusive-or, or, and-with-complement, complement), a truncated multiply, four register-amount shifts and rotates, add and subtract with carry, negate, and three flag-only forms (test, compare, compare-negative). Flags are updated according to the group the operation belongs to. Register-file storage and fetch sit outside the block; a surrounding pipeline feeds operand values and consumes the write strobe.

Top module: `alu16_exec`

## Requirements
- R1: An instruction is accepted only when `in_valid` is high and `insn[15:10]` equals 6'b010000; then `out_valid` is high in the next cycle, `dst_sel` carries `insn[2:0]`, and the operation is `insn[9:6]`. Any other word produces no `out_valid` and no write. Flag buses are ordered {N,Z,C,V} from bit 3 down to bit 0.
- R2: Codes 0 (and), 1 (exclusive-or), 12 (or), 14 (Rd and not Rs) and 15 (not Rs) write their result, set N from bit 31 and Z when the result is zero, and copy C and V from `flags_in`.
- R3: Code 13 writes the low 32 bits of Rd times Rs, with N and Z from that value and C and V copied.
- R4: For codes 2, 3, 4 and 7 the amount is `rs_val[7:0]`; an amount of zero writes Rd unchanged and copies C (and V) from `flags_in`.
- R5: Code 2 shifts Rd left; for amounts 1..31 C is the last bit shifted out, at 32 the result is zero and C is Rd bit 0, above 32 both are zero.
- R6: Code 3 shifts Rd right filling zeros; for amounts 1..31 C is the last bit out, at 32 the result is zero and C is Rd bit 31, above 32 both are zero.
- R7: Code 4 shifts Rd right filling the sign; for amounts of 32 or more every result bit and C equal Rd bit 31.
- R8: Code 7 rotates Rd right by the amount modulo 32; C equals result bit 31, including for nonzero multiples of 32 where the result is Rd.
- R9: Code 5 writes Rd+Rs+C and code 6 writes Rd-Rs-(1-C); both set C as the unsigned carry (no borrow for subtraction), V on signed overflow, and N, Z from the result.
- R10: Code 9 writes 0-Rs, with C set when Rs is zero and V set when Rs is 0x80000000.
- R11: Codes 8 (Rd and Rs), 10 (Rd-Rs) and 11 (Rd+Rs) never raise `wr_en`; they update flags as and-logic, subtraction with carry-in 1, and addition with carry-in 0, and `result` shows the computed value.
- R12: While `rst` is high, and on the first cycle after, `out_valid`, `wr_en`, `result`, `dst_sel` and `flags_out` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands are present |
| insn | input | 16 | Instruction word |
| rd_val | input | 32 | Current value of the destination register |
| rs_val | input | 32 | Current value of the source register |
| flags_in | input | 4 | Incoming flags {N,Z,C,V} |
| out_valid | output | 1 | Registered result is valid |
| result | output | 32 | Computed value |
| wr_en | output | 1 | Write the result to the destination register |
| dst_sel | output | 3 | Destination register index |
| flags_out | output | 4 | Updated flags {N,Z,C,V} |

## Verification
The in-line properties watch, on every cycle, that N and Z always mirror the registered value, that the logic and multiply group never disturbs C and V, that a zero shift amount keeps the carry, that flag-only operations never assert the write strobe and that output only follows an accepted encoding. The exact shifter carry at the 31, 32 and over-32 boundaries, carry and overflow of the add and subtract paths, negate corner values and the rejection of foreign encodings can only be shown by the bench's directed vectors compared against its own reference model.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  localparam logic [5:0] FMT_TAG = 6'b010000;

  typedef enum logic [3:0] {
    OP_AND  = 4'd0,
    OP_XOR  = 4'd1,
    OP_SHL  = 4'd2,
    OP_SHR  = 4'd3,
    OP_SAR  = 4'd4,
    OP_ADDC = 4'd5,
    OP_SUBC = 4'd6,
    OP_ROTR = 4'd7,
    OP_TEST = 4'd8,
    OP_NEG  = 4'd9,
    OP_CMPS = 4'd10,
    OP_CMPA = 4'd11,
    OP_OR   = 4'd12,
    OP_MUL  = 4'd13,
    OP_ANDN = 4'd14,
    OP_NOT  = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    SK_LEFT,
    SK_RIGHT,
    SK_ARITH,
    SK_ROTATE
  } shift_kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

endpackage

// File: rtl/alu16_shifter.sv
module alu16_shifter
  import alu16_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input  shift_kind_e    kind,
  input  logic [DW-1:0]  val,
  input  logic [AW-1:0]  amt,
  input  logic           cin,
  output logic [DW-1:0]  res,
  output logic           cout
);
  // DW is expected to be a power of two so the rotate wraps on amt modulo DW
  localparam int RW = $clog2(DW);

  logic [DW:0]     ext;
  logic [2*DW-1:0] dbl;
  logic [RW-1:0]   rot;

  always_comb begin
    ext  = '0;
    dbl  = '0;
    rot  = amt[RW-1:0];
    res  = val;
    cout = cin;
    if (amt != '0) begin
      unique case (kind)
        SK_LEFT: begin
          // extra top bit catches the last bit that leaves on the left
          ext  = {1'b0, val} << amt;
          res  = ext[DW-1:0];
          cout = ext[DW];
        end
        SK_RIGHT: begin
          ext  = {val, 1'b0} >> amt;
          res  = ext[DW:1];
          cout = ext[0];
        end
        SK_ARITH: begin
          ext  = $unsigned($signed({val, 1'b0}) >>> amt);
          res  = ext[DW:1];
          cout = ext[0];
        end
        SK_ROTATE: begin
          dbl  = {val, val} >> rot;
          res  = dbl[DW-1:0];
          cout = dbl[DW-1];
        end
        default: begin
          res  = val;
          cout = cin;
        end
      endcase
    end
  end

endmodule

// File: rtl/alu16_addsub.sv
module alu16_addsub #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output logic [DW-1:0] sum,
  output logic          cout,
  output logic          ovf
);
  logic [DW:0] wide;

  always_comb begin
    wide = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
    sum  = wide[DW-1:0];
    cout = wide[DW];
    // operands agree in sign but the sum does not
    ovf  = (a[DW-1] == b[DW-1]) && (sum[DW-1] != a[DW-1]);
  end

endmodule

// File: rtl/alu16_exec.sv
module alu16_exec
  import alu16_pkg::*;
#(
  parameter int DW  = 32,
  parameter int IW  = 16,
  parameter int SAW = 8,
  parameter int RIW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [IW-1:0]  insn,
  input  logic [DW-1:0]  rd_val,
  input  logic [DW-1:0]  rs_val,
  input  logic [3:0]     flags_in,
  output logic           out_valid,
  output logic [DW-1:0]  result,
  output logic           wr_en,
  output logic [RIW-1:0] dst_sel,
  output logic [3:0]     flags_out
);
  localparam int OP_LO = 2 * RIW;
  localparam int TAG_LO = OP_LO + 4;

  logic        match;
  alu_op_e     op;
  flags_t      fin;
  flags_t      fnew;
  shift_kind_e skind;
  logic [DW-1:0] sh_res, add_a, add_b, add_sum, nxt_res;
  logic          sh_c, add_ci, add_co, add_v, nxt_wr;

  assign match = (insn[IW-1:TAG_LO] == FMT_TAG);
  assign op    = alu_op_e'(insn[TAG_LO-1:OP_LO]);
  assign fin   = flags_t'(flags_in);

  always_comb begin
    unique case (op)
      OP_SHL:  skind = SK_LEFT;
      OP_SHR:  skind = SK_RIGHT;
      OP_SAR:  skind = SK_ARITH;
      default: skind = SK_ROTATE;
    endcase
  end

  alu16_shifter #(.DW(DW), .AW(SAW)) u_shift (
    .kind (skind),
    .val  (rd_val),
    .amt  (rs_val[SAW-1:0]),
    .cin  (fin.c),
    .res  (sh_res),
    .cout (sh_c)
  );

  // operand steering for the single adder
  always_comb begin
    add_a  = rd_val;
    add_b  = rs_val;
    add_ci = 1'b0;
    unique case (op)
      OP_ADDC: add_ci = fin.c;
      OP_SUBC: begin add_b = ~rs_val; add_ci = fin.c; end
      OP_NEG:  begin add_a = '0; add_b = ~rs_val; add_ci = 1'b1; end
      OP_CMPS: begin add_b = ~rs_val; add_ci = 1'b1; end
      default: ;
    endcase
  end

  alu16_addsub #(.DW(DW)) u_add (
    .a    (add_a),
    .b    (add_b),
    .cin  (add_ci),
    .sum  (add_sum),
    .cout (add_co),
    .ovf  (add_v)
  );

  always_comb begin
    fnew    = fin;
    nxt_wr  = 1'b1;
    nxt_res = '0;
    unique case (op)
      OP_AND:  nxt_res = rd_val & rs_val;
      OP_XOR:  nxt_res = rd_val ^ rs_val;
      OP_OR:   nxt_res = rd_val | rs_val;
      OP_ANDN: nxt_res = rd_val & ~rs_val;
      OP_NOT:  nxt_res = ~rs_val;
      OP_MUL:  nxt_res = rd_val * rs_val;
      OP_TEST: begin nxt_res = rd_val & rs_val; nxt_wr = 1'b0; end
      OP_SHL, OP_SHR, OP_SAR, OP_ROTR: begin
        nxt_res = sh_res;
        fnew.c  = sh_c;
      end
      OP_ADDC, OP_SUBC, OP_NEG: begin
        nxt_res = add_sum;
        fnew.c  = add_co;
        fnew.v  = add_v;
      end
      OP_CMPS, OP_CMPA: begin
        nxt_res = add_sum;
        fnew.c  = add_co;
        fnew.v  = add_v;
        nxt_wr  = 1'b0;
      end
      default: nxt_res = '0;
    endcase
    fnew.n = nxt_res[DW-1];
    fnew.z = (nxt_res == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      result    <= '0;
      dst_sel   <= '0;
      flags_out <= '0;
    end else begin
      out_valid <= in_valid && match;
      wr_en     <= in_valid && match && nxt_wr;
      if (in_valid && match) begin
        result    <= nxt_res;
        dst_sel   <= insn[RIW-1:0];
        flags_out <= fnew;
      end
    end
  end

  // ---------------- assertions ----------------
  assert_reset_R12: assert property (@(posedge clk)
    rst |=> (!out_valid && !wr_en && result == '0 && flags_out == '0));

  assert_accept_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($past(in_valid) && $past(insn[IW-1:TAG_LO]) == FMT_TAG));

  assert_nz_follow_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (flags_out[3] == result[DW-1] && flags_out[2] == (result == '0)));

  assert_keep_cv_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && ($past(insn[TAG_LO-1:OP_LO]) inside {4'd0, 4'd1, 4'd12, 4'd13, 4'd14, 4'd15}))
      |-> (flags_out[1:0] == $past(flags_in[1:0])));

  assert_zero_amount_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && ($past(insn[TAG_LO-1:OP_LO]) inside {4'd2, 4'd3, 4'd4, 4'd7})
      && $past(rs_val[SAW-1:0]) == '0)
      |-> (flags_out[1] == $past(flags_in[1]) && result == $past(rd_val)));

  assert_no_write_R11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && ($past(insn[TAG_LO-1:OP_LO]) inside {4'd8, 4'd10, 4'd11})) |-> !wr_en);

endmodule

// File: tb/sim_alu16_exec.sv
module sim_alu16_exec;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [15:0] insn;
  logic [31:0] rd_val, rs_val;
  logic [3:0]  flags_in;
  logic        out_valid, wr_en;
  logic [31:0] result;
  logic [2:0]  dst_sel;
  logic [3:0]  flags_out;

  alu16_exec u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
    .rd_val(rd_val), .rs_val(rs_val), .flags_in(flags_in),
    .out_valid(out_valid), .result(result), .wr_en(wr_en),
    .dst_sel(dst_sel), .flags_out(flags_out)
  );

  always #(CLK_NS/2) clk = ~clk;

  typedef struct packed {
    logic [31:0] res;
    logic        wr;
    logic [2:0]  dst;
    logic [3:0]  fl;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int checks = 0;
  int fails  = 0;

  // reference built from the requirement text
  function automatic exp_t model(input logic [3:0] op, input logic [31:0] a,
                                 input logic [31:0] b, input logic [3:0] f,
                                 input logic [2:0] dst);
    exp_t   e;
    logic   n, z, c, v;
    logic [31:0] x;
    int     amt;
    longint u, s;
    c = f[1]; v = f[0];
    e.wr = 1'b1; x = '0; amt = int'(b[7:0]);
    case (op)
      4'd0:  x = a & b;
      4'd1:  x = a ^ b;
      4'd12: x = a | b;
      4'd14: x = a & ~b;
      4'd15: x = ~b;
      4'd13: x = 32'(longint'({32'b0, a}) * longint'({32'b0, b}));
      4'd8:  begin x = a & b; e.wr = 1'b0; end
      4'd2:  begin x = a; for (int i = 0; i < amt; i++) begin c = x[31]; x = x << 1; end end
      4'd3:  begin x = a; for (int i = 0; i < amt; i++) begin c = x[0]; x = x >> 1; end end
      4'd4:  begin x = a; for (int i = 0; i < amt; i++) begin c = x[0]; x = {x[31], x[31:1]}; end end
      4'd7:  begin x = a; for (int i = 0; i < amt; i++) begin c = x[0]; x = {x[0], x[31:1]}; end end
      4'd5, 4'd11: begin
        u = longint'({32'b0, a}) + longint'({32'b0, b}) + ((op == 4'd5) ? longint'(f[1]) : 0);
        s = longint'($signed(a)) + longint'($signed(b)) + ((op == 4'd5) ? longint'(f[1]) : 0);
        x = u[31:0]; c = (u > 64'hFFFF_FFFF);
        v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        if (op == 4'd11) e.wr = 1'b0;
      end
      4'd6, 4'd10, 4'd9: begin
        longint ua, sa, br;
        ua = (op == 4'd9) ? 0 : longint'({32'b0, a});
        sa = (op == 4'd9) ? 0 : longint'($signed(a));
        br = (op == 4'd6) ? longint'(!f[1]) : 0;
        u = ua - longint'({32'b0, b}) - br;
        s = sa - longint'($signed(b)) - br;
        x = u[31:0]; c = (u >= 0);
        v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        if (op == 4'd10) e.wr = 1'b0;
      end
      default: x = '0;
    endcase
    n = x[31]; z = (x == '0);
    e.res = x; e.dst = dst; e.fl = {n, z, c, v};
    return e;
  endfunction

  task automatic issue(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [3:0] f, input string tag);
    logic [2:0] d;
    @(negedge clk);
    d = 3'(op) ^ 3'd5;
    insn     = {6'b010000, op, 3'd1, d};
    rd_val   = a;
    rs_val   = b;
    flags_in = f;
    in_valid = 1'b1;
    exp_q.push_back(model(op, a, b, f, d));
    tag_q.push_back(tag);
  endtask

  task automatic reject(input logic [15:0] w);
    @(negedge clk);
    insn = w; rd_val = 32'h1234; rs_val = 32'h1; flags_in = 4'hF; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    checks++;
    if (out_valid !== 1'b0 || wr_en !== 1'b0) begin
      fails++;
      $display("FAIL R1 foreign word %h: out_valid=%b wr_en=%b expected 0 0", w, out_valid, wr_en);
    end
  endtask

  // monitor: compare each produced item against the queue head
  always @(negedge clk) begin
    if (rst === 1'b0 && out_valid === 1'b1) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R1 unexpected out_valid: result=%h expected no output", result);
      end else begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (result !== e.res || wr_en !== e.wr || dst_sel !== e.dst || flags_out !== e.fl) begin
          fails++;
          $display("FAIL %s: res=%h wr=%b dst=%0d fl=%b expected res=%h wr=%b dst=%0d fl=%b",
                   t, result, wr_en, dst_sel, flags_out, e.res, e.wr, e.dst, e.fl);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; insn = '0; rd_val = '0; rs_val = '0; flags_in = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || wr_en !== 1'b0 || result !== '0 || flags_out !== '0 || dst_sel !== '0) begin
      fails++;
      $display("FAIL R12 reset: ov=%b wr=%b res=%h fl=%b expected all zero",
               out_valid, wr_en, result, flags_out);
    end
    rst = 1'b0;

    // R2 logic group, C and V set on entry must survive
    issue(4'd0,  32'hF0F0_1234, 32'h0FF0_FFFF, 4'b0011, "R2 and");
    issue(4'd1,  32'hAAAA_AAAA, 32'hAAAA_AAAA, 4'b0011, "R2 xor to zero");
    issue(4'd12, 32'h8000_0000, 32'h0000_0001, 4'b0010, "R2 or");
    issue(4'd14, 32'hFFFF_FFFF, 32'h0000_FFFF, 4'b0001, "R2 and-not");
    issue(4'd15, 32'h1234_5678, 32'h0000_0000, 4'b0011, "R2 not");
    // R3 multiply
    issue(4'd13, 32'h0001_0000, 32'h0001_0000, 4'b0011, "R3 mul wraps to zero");
    issue(4'd13, 32'hFFFF_FFFF, 32'h0000_0003, 4'b0000, "R3 mul low word");
    // R4 zero amount, upper bits of rs ignored
    issue(4'd2,  32'h8000_0001, 32'h0000_0100, 4'b0010, "R4 shl by zero");
    issue(4'd3,  32'h0000_0001, 32'hFFFF_FF00, 4'b0001, "R4 shr by zero");
    issue(4'd7,  32'h8765_4321, 32'h0000_0000, 4'b0010, "R4 rotr by zero");
    // R5 left shift
    issue(4'd2,  32'h8000_0001, 32'd1,   4'b0000, "R5 shl 1");
    issue(4'd2,  32'h0000_0003, 32'd31,  4'b0000, "R5 shl 31");
    issue(4'd2,  32'h0000_0001, 32'd32,  4'b0000, "R5 shl 32");
    issue(4'd2,  32'hFFFF_FFFF, 32'd33,  4'b0010, "R5 shl 33");
    issue(4'd2,  32'hFFFF_FFFF, 32'd200, 4'b0010, "R5 shl 200");
    // R6 logical right
    issue(4'd3,  32'h0000_0003, 32'd1,   4'b0000, "R6 shr 1");
    issue(4'd3,  32'h8000_0000, 32'd32,  4'b0000, "R6 shr 32");
    issue(4'd3,  32'hFFFF_FFFF, 32'd40,  4'b0010, "R6 shr 40");
    // R7 arithmetic right
    issue(4'd4,  32'h8000_0010, 32'd4,   4'b0000, "R7 sar 4");
    issue(4'd4,  32'h8000_0000, 32'd32,  4'b0000, "R7 sar 32 negative");
    issue(4'd4,  32'h7FFF_FFFF, 32'd77,  4'b0010, "R7 sar 77 positive");
    // R8 rotate
    issue(4'd7,  32'h1234_56F8, 32'd8,   4'b0000, "R8 rotr 8");
    issue(4'd7,  32'h8000_0000, 32'd32,  4'b0000, "R8 rotr 32");
    issue(4'd7,  32'h0000_0010, 32'd36,  4'b0000, "R8 rotr 36");
    // R9 carry arithmetic
    issue(4'd5,  32'hFFFF_FFFF, 32'd1,   4'b0000, "R9 addc carry out");
    issue(4'd5,  32'h7FFF_FFFF, 32'd0,   4'b0010, "R9 addc overflow via carry in");
    issue(4'd6,  32'd5,         32'd3,   4'b0010, "R9 subc C=1");
    issue(4'd6,  32'd5,         32'd3,   4'b0000, "R9 subc C=0");
    issue(4'd6,  32'd3,         32'd5,   4'b0010, "R9 subc borrow");
    issue(4'd6,  32'h8000_0000, 32'd1,   4'b0010, "R9 subc overflow");
    // R10 negate
    issue(4'd9,  32'hDEAD_BEEF, 32'd1,         4'b0000, "R10 neg one");
    issue(4'd9,  32'h0,         32'd0,         4'b0000, "R10 neg zero");
    issue(4'd9,  32'h0,         32'h8000_0000, 4'b0000, "R10 neg min");
    // R11 flag-only forms
    issue(4'd8,  32'hF0F0_0000, 32'h0F0F_0000, 4'b0011, "R11 test zero");
    issue(4'd10, 32'd77,        32'd77,        4'b0000, "R11 compare equal");
    issue(4'd10, 32'd1,         32'd2,         4'b0010, "R11 compare less");
    issue(4'd11, 32'hFFFF_FFFF, 32'd1,         4'b0000, "R11 compare-negative");
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);

    // R1 foreign encodings must not produce output
    reject(16'h4400);
    reject(16'h0000);
    reject(16'hC040);
    repeat (3) @(negedge clk);

    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R1 missing outputs: pending=%0d expected 0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule